// File: doc/BRIEF.md
# Timekeeping Write Gate with Seconds Resynchronisation

This block sits between the serial bus slave of a real-time clock and its timekeeping registers. Host byte writes aimed at the time registers pass through only when a software-controlled write-enable bit is set. That bit is held in a control register that shares the same write path. Every accepted time-register write is routed to exactly one per-register write enable.

The block also owns the one-second prescaler. The prescaler is a binary divider advanced by a 32768 Hz tick enable, so one period is 2^DIV_W enables. After reset the divider does not run. It is frozen from the first accepted time-register byte until the bus STOP that closes that transaction. At that STOP the divider is cleared, so the next seconds tick lands one full period after the STOP. The first such STOP also raises the running indication, which stays high from then on.

Top module: `tk_wgate`

## Requirements
- R1: After reset the write-enable bit is 0, `running` is 0, `sec_tick` is 0 and no `treg_we` bit is set.
- R2: A write to address CTRL_ADDR (default 8) loads the write-enable bit from bit WEN_BIT (default 6) of `wr_data`. The new value governs writes from the next cycle on.
- R3: While the write-enable bit is 1, a `wr_stb` with address a < NREG drives `treg_we` bit a high in that same cycle, with no other bit set. Any other address leaves `treg_we` at zero.
- R4: While the write-enable bit is 0, time-register writes raise no `treg_we` bit. A later STOP neither starts nor realigns the prescaler because of them.
- R5: `running` stays 0 from reset until the first STOP in a transaction that had an accepted time-register write. It rises in the cycle after that STOP and never falls.
- R6: The qualifying STOP clears the prescaler. `sec_tick` pulses for one cycle, in the cycle after the 2^DIV_W-th `tick_en` that follows the STOP.
- R7: From an accepted time-register write until its STOP, `tick_en` does not advance the prescaler and `sec_tick` stays 0.
- R8: A STOP in a transaction with no accepted time-register write leaves the prescaler phase unchanged.
- R9: While running and not held, `sec_tick` recurs once every 2^DIV_W `tick_en` pulses, whether the enables come every cycle or sparsely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 32768 Hz tick enable, one cycle wide |
| wr_stb | input | 1 | Byte write strobe from the bus slave |
| wr_addr | input | ADDR_W | Register address of the byte write |
| wr_data | input | DATA_W | Byte write data |
| stop_stb | input | 1 | Bus STOP detected, one cycle wide |
| treg_we | output | NREG | Per time-register write enable |
| sec_tick | output | 1 | One-second tick, one cycle wide |
| running | output | 1 | Timekeeping started |

## Verification
The address decode is swept over the whole address space with the enable bit both clear and set. This separates accepted writes from ignored ones and confirms the one-hot routing. The divider is then driven with tick enables on every cycle and with sparse patterns, which separates counting of enables from counting of clocks. Writes placed at different divider phases, with enables arriving while the update is in flight, show that the divider holds and then restarts from zero at the STOP. STOPs with no time write, or with only rejected writes, show that the phase survives untouched.

// File: rtl/tk_wgate_pkg.sv
package tk_wgate_pkg;
   typedef enum logic [1:0] {
      PS_IDLE       = 2'd0,
      PS_ARM_FIRST  = 2'd1,
      PS_RUN        = 2'd2,
      PS_ARM_RESYNC = 2'd3
   } ps_state_t;

   function automatic logic ps_is_running(input ps_state_t s);
      return (s == PS_RUN) || (s == PS_ARM_RESYNC);
   endfunction

   function automatic logic ps_is_armed(input ps_state_t s);
      return (s == PS_ARM_FIRST) || (s == PS_ARM_RESYNC);
   endfunction
endpackage

// File: rtl/tk_wen_reg.sv
module tk_wen_reg #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 8,
   parameter int WEN_BIT   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wen
);
   localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);

   logic hit;
   assign hit = wr_stb && (wr_addr == CtrlA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen <= 1'b0;
      end else if (hit) begin
         wen <= wr_data[WEN_BIT];
      end
   end
endmodule

// File: rtl/tk_addr_gate.sv
module tk_addr_gate #(
   parameter int ADDR_W = 4,
   parameter int NREG   = 7
) (
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wen,
   output logic [NREG-1:0]   treg_we,
   output logic              accept
);
   logic pass;
   assign pass = wr_stb && wen;

   for (genvar i = 0; i < NREG; i++) begin : g_dec
      localparam logic [ADDR_W-1:0] MyA = ADDR_W'(i);
      assign treg_we[i] = pass && (wr_addr == MyA);
   end

   assign accept = |treg_we;
endmodule

// File: rtl/tk_sec_prescaler.sv
module tk_sec_prescaler
   import tk_wgate_pkg::*;
#(
   parameter int DIV_W = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic accept,
   input  logic stop_stb,
   output logic sec_tick,
   output logic running
);
   localparam logic [DIV_W-1:0] CntMax = {DIV_W{1'b1}};

   ps_state_t        st;
   logic [DIV_W-1:0] cnt;
   logic             hold;
   logic             count_en;

   assign running  = ps_is_running(st);
   assign hold     = ps_is_armed(st) || accept;
   assign count_en = running && !hold && tick_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= PS_IDLE;
         cnt      <= '0;
         sec_tick <= 1'b0;
      end else begin
         sec_tick <= count_en && (cnt == CntMax);
         if (stop_stb && hold) begin
            st  <= PS_RUN;
            cnt <= '0;
         end else if (accept) begin
            case (st)
               PS_IDLE: st <= PS_ARM_FIRST;
               PS_RUN:  st <= PS_ARM_RESYNC;
               default: st <= st;
            endcase
         end else if (count_en) begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tk_wgate.sv
module tk_wgate #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int NREG      = 7,
   parameter int CTRL_ADDR = 8,
   parameter int WEN_BIT   = 6,
   parameter int DIV_W     = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              stop_stb,
   output logic [NREG-1:0]   treg_we,
   output logic              sec_tick,
   output logic              running
);
   if (DIV_W < 2) begin : g_bad_div
      $error("tk_wgate: DIV_W must be at least 2");
   end
   if (NREG < 1 || NREG > CTRL_ADDR) begin : g_bad_nreg
      $error("tk_wgate: NREG must be in 1..CTRL_ADDR");
   end
   if (CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_ctrl
      $error("tk_wgate: CTRL_ADDR outside address space");
   end
   if (WEN_BIT >= DATA_W) begin : g_bad_bit
      $error("tk_wgate: WEN_BIT outside data width");
   end

   logic wen_q;
   logic accept;

   tk_wen_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CTRL_ADDR(CTRL_ADDR), .WEN_BIT(WEN_BIT)
   ) u_wen (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
      .wr_addr(wr_addr), .wr_data(wr_data), .wen(wen_q)
   );

   tk_addr_gate #(.ADDR_W(ADDR_W), .NREG(NREG)) u_gate (
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wen(wen_q),
      .treg_we(treg_we), .accept(accept)
   );

   tk_sec_prescaler #(.DIV_W(DIV_W)) u_ps (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .accept(accept), .stop_stb(stop_stb),
      .sec_tick(sec_tick), .running(running)
   );
endmodule

// File: rtl/tk_wgate_chk.sv
module tk_wgate_chk #(
   parameter int NREG = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_stb,
   input logic            stop_stb,
   input logic            wen_q,
   input logic [NREG-1:0] treg_we,
   input logic            sec_tick,
   input logic            running
);
   // R3: at most one register strobe at a time
   a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(treg_we));

   // R3: a register strobe needs a bus write
   a_r3_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (|treg_we) |-> wr_stb);

   // R4: disabled gate passes nothing
   a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !wen_q |-> (treg_we == '0));

   // R5: running never falls
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> running);

   // R5/R6: STOP closing an accepted write starts the clock
   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_stb && (|treg_we)) |=> running);

   // R7: no tick right after a mid-update write
   a_r7_no_tick_held: assert property (@(posedge clk) disable iff (!rst_n)
      ((|treg_we) && !stop_stb) |=> !sec_tick);

   // R9: ticks only while running
   a_r9_tick_running: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> running);
endmodule

bind tk_wgate tk_wgate_chk #(.NREG(NREG)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .stop_stb(stop_stb),
   .wen_q(wen_q), .treg_we(treg_we), .sec_tick(sec_tick), .running(running)
);

// File: tb/tk_wgate_test.sv
module tk_wgate_test;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;
   localparam int NREG = 8;
   localparam int CTRL_ADDR = 8;
   localparam int WEN_BIT = 6;
   localparam int DIV_W = 4;
   localparam int MOD = 1 << DIV_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0;
   logic wr_stb = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic stop_stb = 1'b0;
   logic [NREG-1:0] treg_we;
   logic sec_tick;
   logic running;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   // reference state computed from the requirements
   bit wen_m = 0, run_m = 0, pend_m = 0, sec_m = 0;
   int ph = 0;
   string tag_sec = "R6";
   string tag_we = "R3";

   always #(CLK_PERIOD/2) clk = ~clk;

   tk_wgate #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG),
      .CTRL_ADDR(CTRL_ADDR), .WEN_BIT(WEN_BIT), .DIV_W(DIV_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_stb(wr_stb),
      .wr_addr(wr_addr), .wr_data(wr_data), .stop_stb(stop_stb),
      .treg_we(treg_we), .sec_tick(sec_tick), .running(running)
   );

   task automatic check(input int act, input int exp, input string tag, input string what);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input bit wr, input int addr, input bit [7:0] data,
                       input bit stp, input bit tk);
      bit acc, hold;
      int exp_we;
      @(negedge clk);
      wr_stb = wr; wr_addr = ADDR_W'(addr); wr_data = data;
      stop_stb = stp; tick_en = tk;
      #1;
      acc = wr && wen_m && (addr < NREG);
      exp_we = acc ? (1 << addr) : 0;
      check(int'(treg_we), exp_we, wen_m ? tag_we : "R4", "treg_we");
      hold = pend_m || acc;
      sec_m = run_m && !hold && tk && (ph == MOD - 1);
      if (stp && hold) begin
         ph = 0; run_m = 1; pend_m = 0;
      end else begin
         if (acc) pend_m = 1;
         if (run_m && !hold && tk) ph = (ph + 1) % MOD;
      end
      if (wr && addr == CTRL_ADDR) wen_m = data[WEN_BIT];
      @(posedge clk);
      #(CLK_PERIOD/4);
      check(int'(running), int'(run_m), "R5", "running");
      check(int'(sec_tick), int'(sec_m), tag_sec, "sec_tick");
   endtask

   task automatic idle_ticks(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         step(0, 0, 0, 0, (gap == 0) ? 1'b1 : ((i % gap) == 0));
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(int'(treg_we), 0, "R1", "treg_we");
      check(int'(sec_tick), 0, "R1", "sec_tick");
      check(int'(running), 0, "R1", "running");
      @(negedge clk); rst_n = 1'b1;

      // R4: gate closed, sweep all addresses, then STOP must not start
      for (int a = 0; a < (1 << ADDR_W); a++) begin
         if (a != CTRL_ADDR) step(1, a, 8'hFF, 0, 1);
      end
      step(0, 0, 0, 1, 1);
      tag_sec = "R4";
      idle_ticks(2 * MOD, 0);

      // R2: open the gate, then full decode sweep (R3)
      tag_we = "R2";
      step(1, CTRL_ADDR, 8'h40, 0, 0);
      step(1, 0, 8'h00, 0, 0);
      tag_we = "R3";
      for (int a = 0; a < (1 << ADDR_W); a++) begin
         step(1, a, (a == CTRL_ADDR) ? 8'h40 : 8'h5A, 0, 1);
      end

      // R7: held before first STOP, R5 still low
      tag_sec = "R7";
      idle_ticks(MOD + 3, 0);
      // R6: STOP starts, first tick one full period later
      tag_sec = "R6";
      step(0, 0, 0, 1, 1);
      idle_ticks(MOD + 2, 0);
      // R9: recurring with sparse enables
      tag_sec = "R9";
      idle_ticks(3 * MOD * 3, 3);
      idle_ticks(2 * MOD * 2, 2);

      // R8: STOP without time write mid-period keeps phase
      tag_sec = "R8";
      idle_ticks(5, 0);
      step(0, 0, 0, 1, 1);
      step(1, CTRL_ADDR, 8'h40, 1, 1);
      idle_ticks(2 * MOD, 0);

      // R4: close gate during run, rejected write + STOP keeps phase
      tag_we = "R2";
      step(1, CTRL_ADDR, 8'h00, 0, 1);
      tag_sec = "R4";
      step(1, 2, 8'h11, 0, 1);
      step(0, 0, 0, 1, 1);
      idle_ticks(2 * MOD, 0);

      // R7/R6: resync writes at several phases, with enables while held
      tag_we = "R3";
      step(1, CTRL_ADDR, 8'h40, 0, 1);
      for (int k = 0; k < 4; k++) begin
         tag_sec = "R7";
         idle_ticks(k * 3 + 1, 0);
         step(1, k, 8'h22, 0, 1);
         step(1, k + 1, 8'h23, 0, 1);
         idle_ticks(MOD + k, 0);
         tag_sec = "R6";
         step(0, 0, 0, 1, (k % 2) == 1);
         idle_ticks(MOD + 1, 0);
      end
      // R6: write and STOP in the same cycle
      step(1, 5, 8'h33, 1, 1);
      idle_ticks(2 * MOD + 1, 0);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule